// File: doc/BRIEF.md
# Conditional Pattern Fault Injector

This block sits in series with a vector of internal signal lines and corrupts exactly one of them, the victim, while a programmed activation condition holds. It is meant to emulate defect behaviours such as dominant or wired bridges and transition-triggered faults inside a running design. Every other line passes through unchanged.

The activation condition is a single product term. Each line is either ignored or required to carry a given value. In static mode only the present values are compared. In dynamic mode a second product term must also hold on the values the lines carried in the previous clock cycle. That history is captured in a register, which is marked invalid at reset. The fault effect is directional. A 0-to-1 effect sets the victim only when it is 0, and a 1-to-0 effect clears it only when it is 1. When both effects are enabled, the victim is inverted. Both the corrupted vector and the active flag are combinational from the present inputs and the stored history.

Top module: `cond_fault_injector`

## Requirements
- R1: With `enable` low, `lines_out` equals `lines_in` and `fault_active` is 0, whatever the configuration.
- R2: In static mode (`dyn_mode`=0, `enable`=1), `fault_active` is 1 exactly when every line whose `care_mask` bit is 1 carries the matching bit of `req_val` in the same cycle.
- R3: An all-zero `care_mask` makes the present-value term true for any `lines_in`.
- R4: With `set_en`=1 and `clr_en`=0, while the fault is active, a victim at 0 is output as 1 and a victim at 1 is output unchanged.
- R5: With `clr_en`=1 and `set_en`=0, while the fault is active, a victim at 1 is output as 0 and a victim at 0 is output unchanged.
- R6: With `set_en` and `clr_en` both 1, the victim is inverted whenever the fault is active.
- R7: Only the line selected by `victim_sel` (bit index, LSB = line 0) can ever differ between `lines_in` and `lines_out`.
- R8: In dynamic mode, `fault_active` is 1 exactly when the previous cycle's `lines_in` matched `init_val` on the `init_mask` lines, the present `lines_in` match `req_val` on the `care_mask` lines, and the history is valid.
- R9: Stored history is invalid until the first rising clock edge after reset is released, so a dynamic fault cannot be active in that first cycle, even with both masks zero.
- R10: With both effect bits 0, `fault_active` may assert but `lines_out` equals `lines_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global injection enable |
| dyn_mode | input | 1 | 1 selects dynamic mode (history term used) |
| care_mask | input | N_LINES | Lines included in the present-value term |
| req_val | input | N_LINES | Required present values |
| init_mask | input | N_LINES | Lines included in the previous-cycle term |
| init_val | input | N_LINES | Required previous-cycle values |
| victim_sel | input | IDX_W | Index of the victim line |
| set_en | input | 1 | Enable the 0-to-1 effect |
| clr_en | input | 1 | Enable the 1-to-0 effect |
| lines_in | input | N_LINES | Signal lines entering the injector |
| lines_out | output | N_LINES | Possibly corrupted signal lines |
| fault_active | output | 1 | Activation condition holds this cycle |

## Verification
On every cycle the assertions enforce pass-through when disabled and when no effect is enabled. They also check that at most one line, the victim, ever changes, and that the change points in an allowed direction. They further check that activation implies the present-value match and, in dynamic mode, the previous-cycle match, and that nothing dynamic fires in the first cycle after reset. Only the bench scenarios can show the converse: that activation happens whenever the condition holds, including the bridge and transition examples, an all-zero care mask and double-effect inversion.

// File: rtl/cond_fault_injector.sv
module cond_fault_injector #(
  parameter int N_LINES = 8,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               dyn_mode,
  input  logic [N_LINES-1:0] care_mask,
  input  logic [N_LINES-1:0] req_val,
  input  logic [N_LINES-1:0] init_mask,
  input  logic [N_LINES-1:0] init_val,
  input  logic [IDX_W-1:0]   victim_sel,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic [N_LINES-1:0] lines_in,
  output logic [N_LINES-1:0] lines_out,
  output logic               fault_active
);

  logic [N_LINES-1:0] prev_q;
  logic               prev_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      prev_ok <= 1'b0;
    end else begin
      prev_q  <= lines_in;
      prev_ok <= 1'b1;
    end
  end

  logic               now_hit, hist_hit, vic_bit, flip;
  logic [N_LINES-1:0] vic_mask;

  assign now_hit  = ((lines_in ^ req_val) & care_mask) == '0;
  assign hist_hit = prev_ok && (((prev_q ^ init_val) & init_mask) == '0);

  assign vic_mask = (int'(victim_sel) < N_LINES) ? (N_LINES'(1) << victim_sel) : '0;
  assign vic_bit  = |(lines_in & vic_mask);

  assign fault_active = enable && now_hit && (!dyn_mode || hist_hit);
  assign flip         = fault_active && ((set_en && !vic_bit) || (clr_en && vic_bit));
  assign lines_out    = flip ? (lines_in ^ vic_mask) : lines_in;

endmodule

// File: rtl/cond_fault_injector_chk.sv
module cond_fault_injector_chk #(
  parameter int N_LINES = 8,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               dyn_mode,
  input logic [N_LINES-1:0] care_mask,
  input logic [N_LINES-1:0] req_val,
  input logic [N_LINES-1:0] init_mask,
  input logic [N_LINES-1:0] init_val,
  input logic [IDX_W-1:0]   victim_sel,
  input logic               set_en,
  input logic               clr_en,
  input logic [N_LINES-1:0] lines_in,
  input logic [N_LINES-1:0] lines_out,
  input logic               fault_active
);

  logic               seen_edge;
  logic [N_LINES-1:0] diff, sel_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
  end

  assign diff    = lines_out ^ lines_in;
  assign sel_one = N_LINES'(1) << victim_sel;

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (lines_out == lines_in) && !fault_active); // R1

  AST_STATIC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_active && !dyn_mode) |-> (((lines_in ^ req_val) & care_mask) == '0)); // R2

  AST_SET_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && diff != '0) |-> ((lines_out & diff) == diff)); // R4

  AST_CLR_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && diff != '0) |-> ((lines_out & diff) == '0)); // R5

  AST_VICTIM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(diff) && ((diff & ~sel_one) == '0)); // R7

  AST_DYN_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_active && dyn_mode && seen_edge) |->
      ((($past(lines_in) ^ init_val) & init_mask) == '0)); // R8

  AST_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_edge |-> !(fault_active && dyn_mode)); // R9

  AST_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |-> (lines_out == lines_in)); // R10

endmodule

bind cond_fault_injector cond_fault_injector_chk #(.N_LINES(N_LINES)) u_chk (.*);

// File: tb/cond_fault_injector_tb.sv
module cond_fault_injector_tb;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, dyn_mode = 1'b0, set_en = 1'b0, clr_en = 1'b0;
  logic [N-1:0] care_mask = '0, req_val = '0, init_mask = '0, init_val = '0, lines_in = '0;
  logic [IW-1:0] victim_sel = '0;
  logic [N-1:0] lines_out;
  logic fault_active;

  int n_checks = 0, n_fail = 0;
  logic [N-1:0] hist = '0;
  logic hist_ok = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  cond_fault_injector #(.N_LINES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dyn_mode(dyn_mode),
    .care_mask(care_mask), .req_val(req_val), .init_mask(init_mask),
    .init_val(init_val), .victim_sel(victim_sel), .set_en(set_en),
    .clr_en(clr_en), .lines_in(lines_in), .lines_out(lines_out),
    .fault_active(fault_active));

  function automatic logic exp_active();
    logic now_ok, old_ok;
    now_ok = ((lines_in & care_mask) == (req_val & care_mask));
    old_ok = hist_ok && ((hist & init_mask) == (init_val & init_mask));
    return enable && now_ok && (!dyn_mode || old_ok);
  endfunction

  function automatic logic [N-1:0] exp_out(input logic act);
    logic [N-1:0] r;
    logic v;
    r = lines_in;
    v = lines_in[victim_sel];
    if (act && !v && set_en) r[victim_sel] = 1'b1;
    if (act && v && clr_en)  r[victim_sel] = 1'b0;
    return r;
  endfunction

  task automatic check(input string req);
    logic a;
    logic [N-1:0] o;
    a = exp_active();
    o = exp_out(a);
    n_checks++;
    if (fault_active !== a || lines_out !== o) begin
      n_fail++;
      $display("FAIL %s: got active=%0b out=%h, expected active=%0b out=%h",
               req, fault_active, lines_out, a, o);
    end
  endtask

  task automatic step(input logic [N-1:0] v, input string req);
    @(negedge clk);
    lines_in = v;
    #1;
    check(req);
    @(posedge clk);
    hist = v;
    hist_ok = 1'b1;
  endtask

  task automatic cfg(input logic en, input logic dm, input logic [N-1:0] cm,
                     input logic [N-1:0] rv, input logic [N-1:0] im,
                     input logic [N-1:0] iv, input int vic, input logic se,
                     input logic ce);
    enable = en; dyn_mode = dm; care_mask = cm; req_val = rv;
    init_mask = im; init_val = iv; victim_sel = IW'(vic); set_en = se; clr_en = ce;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    hist_ok = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R9: dynamic with zero masks in first cycle after reset stays inactive
    cfg(1, 1, '0, '0, '0, '0, 0, 1, 1);
    do_reset();
    lines_in = 8'h00;
    #1;
    n_checks++;
    if (fault_active !== 1'b0 || lines_out !== 8'h00) begin
      n_fail++;
      $display("FAIL R9: got active=%0b out=%h, expected active=0 out=00", fault_active, lines_out);
    end
    @(posedge clk); hist = 8'h00; hist_ok = 1'b1;
    step(8'h00, "R9");          // second cycle: now fires and inverts bit 0

    // R1 disabled pass-through
    cfg(0, 0, '0, '0, '0, '0, 3, 1, 1);
    step(8'h00, "R1");
    step(8'hF7, "R1");

    // R3 zero care mask, static, R6 inversion
    cfg(1, 0, '0, '0, '0, '0, 5, 1, 1);
    step(8'h00, "R3");
    step(8'hFF, "R6");

    // OR-type bridge: aggressor bit 2 at 1 sets victim bit 4 (R4, R2)
    cfg(1, 0, 8'h04, 8'h04, '0, '0, 4, 1, 0);
    step(8'h04, "R4");
    step(8'h14, "R4");
    step(8'h00, "R2");
    step(8'hFB, "R2");

    // R5 clear effect
    cfg(1, 0, 8'h81, 8'h80, '0, '0, 6, 0, 1);
    step(8'hC0, "R5");
    step(8'h80, "R5");
    step(8'hC1, "R2");

    // R10 no effect bits
    cfg(1, 0, '0, '0, '0, '0, 1, 0, 0);
    step(8'h5A, "R10");

    // R8 dynamic: bits0,1 were 00, now a=1 b=0; victim bit2 at 1 forced to 0
    cfg(1, 1, 8'h03, 8'h01, 8'h03, 8'h00, 2, 0, 1);
    step(8'h04, "R8");
    step(8'h05, "R8");
    step(8'h05, "R8");          // history now 01: no fire
    step(8'h06, "R8");
    step(8'h04, "R8");
    step(8'h05, "R8");

    // R9 again after a mid-run reset
    do_reset();
    lines_in = 8'h05;
    #1;
    n_checks++;
    if (fault_active !== 1'b0 || lines_out !== 8'h05) begin
      n_fail++;
      $display("FAIL R9: got active=%0b out=%h, expected active=0 out=05", fault_active, lines_out);
    end
    @(posedge clk); hist = 8'h05; hist_ok = 1'b1;

    // Random mix, R2 R7 R8 R4 R5 R6
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] v;
      v = N'($urandom);
      enable    = ($urandom % 8) != 0;
      dyn_mode  = $urandom % 2;
      care_mask = N'($urandom & $urandom & $urandom);
      req_val   = ($urandom % 2) ? v : N'($urandom);
      init_mask = N'($urandom & $urandom);
      init_val  = ($urandom % 2) ? hist : N'($urandom);
      victim_sel = IW'($urandom);
      set_en    = $urandom % 2;
      clr_en    = $urandom % 2;
      step(v, "R7");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule